// File: doc/BRIEF.md
# Runahead Mode Pipeline Controller

This block lets a simple in-order pipeline keep working after a blocking data-cache miss instead of stalling. When a load misses in normal operation, the controller copies the whole architectural register file into a shadow copy and records the load's PC. It then switches to runahead mode. While in runahead mode, every result that depends on missing data carries an invalid tag. Loads and stores with valid addresses can still send prefetch requests to memory, so later misses overlap with the first one.

For each instruction presented to it, the controller decides three things. It decides whether the result is tagged invalid. It decides whether a memory request may go out. It decides whether a branch must hold because its operands are not known. The controller holds the live register file with one write port and one read port, plus the per-register invalid bits. It tracks outstanding memory requests, assuming they return in issue order, so it knows when the offending miss comes back.

The controller leaves runahead mode at one of two points, chosen by a configuration input: as soon as the offending miss returns, or only once every outstanding request has returned. On exit it restores the shadow copy and clears every invalid bit. It then raises a restore strobe, a flush pulse and a redirect to the saved PC, so the missing load executes again. The datapath, the caches and the branch predictor lie outside this block.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset the block is in normal mode. All registers read zero with clear invalid bits, and ckpt_o, restore_o, flush_o, stall_o and mem_issue_o are low.
- R2: A valid load (kind 1) with dc_hit_i low, presented in normal mode, raises ckpt_o, flush_o, inv_o and mem_issue_o in that cycle. From the next cycle runahead_o is high, the load's destination reads as invalid, and redirect_pc_o holds that load's PC.
- R3: When an instruction writes its destination (dst_wr_i high, kind 0 ALU or kind 1 load), a result tagged invalid sets that register's invalid bit. A valid result stores result_i and clears the bit. An ALU result is invalid when source A is invalid, or when source B is used (src_b_used_i) and invalid.
- R4: In runahead mode, a load or store (kind 2) whose address register, source A, is invalid issues no memory request. Such a load's result is invalid.
- R5: In runahead mode, a load or store with a valid address that misses issues a prefetch only if line_busy_i is low and fewer than MAX_OUT requests are outstanding. A runahead load miss is tagged invalid and takes no new checkpoint.
- R6: stall_o is high exactly for a valid branch (kind 3) in runahead mode with an invalid source operand.
- R7: dc_write_o is high for a valid store in normal mode and never high in runahead mode.
- R8: With exit_all_i low, in the cycle after the refill_done_i pulse that returns the offending miss, restore_o, flush_o and redirect_o are high. In that cycle redirect_pc_o equals the saved load PC, and runahead_o is low from the next cycle.
- R9: With exit_all_i high, exit happens only in a cycle where the offending miss has returned and no request is outstanding.
- R10: After exit every register reads exactly the value it held when the checkpoint was taken, and every invalid bit is clear.
- R11: An instruction presented in the exit cycle has no effect. It issues no request, raises no stall or invalid flag and writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exit_all_i | input | 1 | Exit policy: 0 exit on offending return, 1 wait for all requests |
| ins_valid_i | input | 1 | An instruction is presented this cycle |
| ins_kind_i | input | 2 | 0 ALU, 1 load, 2 store, 3 branch |
| ins_pc_i | input | PCW | PC of the presented instruction |
| src_a_i | input | REGW | Source A index (address register for memory ops) |
| src_b_i | input | REGW | Source B index |
| src_b_used_i | input | 1 | Source B is read |
| dst_i | input | REGW | Destination index |
| dst_wr_i | input | 1 | Instruction writes its destination |
| result_i | input | XLEN | Result value from the datapath |
| dc_hit_i | input | 1 | Data-cache lookup hit for this load or store |
| line_busy_i | input | 1 | Target cache line is occupied by an outstanding fill |
| refill_done_i | input | 1 | One outstanding request returned (in issue order) |
| rd_idx_i | input | REGW | Read port index |
| rd_data_o | output | XLEN | Read port data |
| rd_inv_o | output | 1 | Read port invalid bit |
| runahead_o | output | 1 | Runahead mode active |
| ckpt_o | output | 1 | Checkpoint strobe |
| restore_o | output | 1 | Restore strobe |
| flush_o | output | 1 | One-cycle pipeline flush on entry and exit |
| redirect_o | output | 1 | Fetch redirect request |
| redirect_pc_o | output | PCW | Restart PC (saved load PC) |
| inv_o | output | 1 | Current result is invalid |
| mem_issue_o | output | 1 | Memory request enable |
| dc_write_o | output | 1 | Data-cache write enable |
| stall_o | output | 1 | Hold the pipeline at this branch |

## Verification
The assertions check the per-cycle rules on every cycle: no cache write in runahead mode, no request from an invalid address or onto a busy line, stalls only at branches in runahead mode, and no effect from instructions in the exit cycle. They also check that every invalid bit is clear after exit and that the restart PC holds steady during runahead. Only the bench scenarios can show the rules that depend on history. These are the exact register contents restored after exit, the choice of exit cycle under each policy once earlier and later requests are interleaved, and the values written by valid results during runahead mode.

// File: rtl/runahead_pkg.sv
`timescale 1ns/1ps
package runahead_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_LOAD   = 2'd1,
    K_STORE  = 2'd2,
    K_BRANCH = 2'd3
  } ins_kind_e;
endpackage

// File: rtl/ra_ckpt_rf.sv
`timescale 1ns/1ps
// Live register file plus a shadow copy taken on entry and restored on exit.
module ra_ckpt_rf #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  parameter int REGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [REGW-1:0] wr_idx_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            snap_i,
  input  logic            restore_i,
  input  logic [REGW-1:0] rd_idx_i,
  output logic [XLEN-1:0] rd_data_o
);
  logic [XLEN-1:0] live_vec [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [XLEN-1:0] live_q, live_d, shad_q;
    logic            wr_hit;

    assign wr_hit = wr_en_i && (wr_idx_i == REGW'(g));

    always_comb begin
      live_d = live_q;
      if (restore_i)   live_d = shad_q;
      else if (wr_hit) live_d = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= '0;
      else        live_q <= live_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shad_q <= '0;
      else if (snap_i) shad_q <= live_q;
    end

    assign live_vec[g] = live_q;
  end

  assign rd_data_o = live_vec[rd_idx_i];
endmodule

// File: rtl/ra_inv_track.sv
`timescale 1ns/1ps
// One invalid bit per architectural register.
module ra_inv_track #(
  parameter int NREG = 16,
  parameter int REGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_all_i,
  input  logic            upd_i,
  input  logic [REGW-1:0] upd_idx_i,
  input  logic            upd_inv_i,
  output logic [NREG-1:0] inv_o
);
  logic [NREG-1:0] inv_q, inv_d;

  always_comb begin
    inv_d = inv_q;
    if (clear_all_i)  inv_d = '0;
    else if (upd_i)   inv_d[upd_idx_i] = upd_inv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_q <= '0;
    else        inv_q <= inv_d;
  end

  assign inv_o = inv_q;
endmodule

// File: rtl/ra_mode_ctl.sv
`timescale 1ns/1ps
// Mode register, restart PC, outstanding-request count and exit decision.
module ra_mode_ctl #(
  parameter int PCW     = 32,
  parameter int MAX_OUT = 8,
  parameter int CNTW    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exit_all_i,
  input  logic           entry_i,
  input  logic           issue_i,
  input  logic           refill_i,
  input  logic [PCW-1:0] pc_i,
  output logic           ra_o,
  output logic           exit_o,
  output logic           full_o,
  output logic [PCW-1:0] saved_pc_o
);
  logic            ra_q, ra_d;
  logic            back_q, back_d;
  logic [CNTW-1:0] ahead_q, ahead_d;
  logic [CNTW-1:0] out_q, out_d;
  logic [PCW-1:0]  spc_q;
  logic            exit_now;

  assign exit_now = ra_q && back_q && (!exit_all_i || (out_q == '0));

  always_comb begin
    ra_d    = ra_q;
    back_d  = back_q;
    ahead_d = ahead_q;
    out_d   = out_q + CNTW'(issue_i) - CNTW'(refill_i);
    if (exit_now) begin
      ra_d   = 1'b0;
      back_d = 1'b0;
    end else if (entry_i) begin
      ra_d    = 1'b1;
      back_d  = 1'b0;
      ahead_d = out_q - CNTW'(refill_i);
    end else if (ra_q && refill_i && !back_q) begin
      if (ahead_q == '0) back_d  = 1'b1;
      else               ahead_d = ahead_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q    <= 1'b0;
      back_q  <= 1'b0;
      ahead_q <= '0;
      out_q   <= '0;
    end else begin
      ra_q    <= ra_d;
      back_q  <= back_d;
      ahead_q <= ahead_d;
      out_q   <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       spc_q <= '0;
    else if (entry_i) spc_q <= pc_i;
  end

  assign ra_o       = ra_q;
  assign exit_o     = exit_now;
  assign full_o     = (out_q == CNTW'(MAX_OUT));
  assign saved_pc_o = spc_q;
endmodule

// File: rtl/ra_issue_ctl.sv
`timescale 1ns/1ps
// Per-instruction decisions: invalid result, request issue, stall, writes.
module ra_issue_ctl
  import runahead_pkg::*;
(
  input  logic      valid_i,
  input  ins_kind_e kind_i,
  input  logic      ra_i,
  input  logic      exit_i,
  input  logic      inv_a_i,
  input  logic      inv_b_i,
  input  logic      use_b_i,
  input  logic      dst_wr_i,
  input  logic      hit_i,
  input  logic      busy_i,
  input  logic      full_i,
  output logic      entry_o,
  output logic      inv_res_o,
  output logic      issue_o,
  output logic      dc_write_o,
  output logic      stall_o,
  output logic      wr_en_o
);
  logic act, is_alu, is_ld, is_st, is_br, src_inv, prefetch_ok;

  always_comb begin
    act     = valid_i && !exit_i;
    is_alu  = (kind_i == K_ALU);
    is_ld   = (kind_i == K_LOAD);
    is_st   = (kind_i == K_STORE);
    is_br   = (kind_i == K_BRANCH);
    src_inv = inv_a_i || (use_b_i && inv_b_i);

    prefetch_ok = ra_i && act && (is_ld || is_st) && !inv_a_i && !hit_i
                  && !busy_i && !full_i;

    entry_o    = act && !ra_i && is_ld && !hit_i;
    inv_res_o  = act && ((is_alu && src_inv) || (is_ld && (inv_a_i || !hit_i)));
    issue_o    = entry_o || prefetch_ok;
    dc_write_o = act && !ra_i && is_st;
    stall_o    = act && ra_i && is_br && src_inv;
    wr_en_o    = act && dst_wr_i && (is_alu || is_ld);
  end
endmodule

// File: rtl/runahead_ctrl.sv
`timescale 1ns/1ps
module runahead_ctrl
  import runahead_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int XLEN    = 32,
  parameter int PCW     = 32,
  parameter int MAX_OUT = 8,
  localparam int REGW   = $clog2(NREG),
  localparam int CNTW   = $clog2(MAX_OUT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exit_all_i,
  input  logic            ins_valid_i,
  input  logic [1:0]      ins_kind_i,
  input  logic [PCW-1:0]  ins_pc_i,
  input  logic [REGW-1:0] src_a_i,
  input  logic [REGW-1:0] src_b_i,
  input  logic            src_b_used_i,
  input  logic [REGW-1:0] dst_i,
  input  logic            dst_wr_i,
  input  logic [XLEN-1:0] result_i,
  input  logic            dc_hit_i,
  input  logic            line_busy_i,
  input  logic            refill_done_i,
  input  logic [REGW-1:0] rd_idx_i,
  output logic [XLEN-1:0] rd_data_o,
  output logic            rd_inv_o,
  output logic            runahead_o,
  output logic            ckpt_o,
  output logic            restore_o,
  output logic            flush_o,
  output logic            redirect_o,
  output logic [PCW-1:0]  redirect_pc_o,
  output logic            inv_o,
  output logic            mem_issue_o,
  output logic            dc_write_o,
  output logic            stall_o
);
  logic [NREG-1:0] inv_vec;
  logic            ra, exit_now, full, entry, inv_res, issue, wr_en;

  ra_mode_ctl #(.PCW(PCW), .MAX_OUT(MAX_OUT), .CNTW(CNTW)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .exit_all_i (exit_all_i),
    .entry_i    (entry),
    .issue_i    (issue),
    .refill_i   (refill_done_i),
    .pc_i       (ins_pc_i),
    .ra_o       (ra),
    .exit_o     (exit_now),
    .full_o     (full),
    .saved_pc_o (redirect_pc_o)
  );

  ra_issue_ctl u_issue (
    .valid_i    (ins_valid_i),
    .kind_i     (ins_kind_e'(ins_kind_i)),
    .ra_i       (ra),
    .exit_i     (exit_now),
    .inv_a_i    (inv_vec[src_a_i]),
    .inv_b_i    (inv_vec[src_b_i]),
    .use_b_i    (src_b_used_i),
    .dst_wr_i   (dst_wr_i),
    .hit_i      (dc_hit_i),
    .busy_i     (line_busy_i),
    .full_i     (full),
    .entry_o    (entry),
    .inv_res_o  (inv_res),
    .issue_o    (issue),
    .dc_write_o (dc_write_o),
    .stall_o    (stall_o),
    .wr_en_o    (wr_en)
  );

  ra_inv_track #(.NREG(NREG), .REGW(REGW)) u_inv (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_all_i (exit_now),
    .upd_i       (wr_en),
    .upd_idx_i   (dst_i),
    .upd_inv_i   (inv_res),
    .inv_o       (inv_vec)
  );

  ra_ckpt_rf #(.NREG(NREG), .XLEN(XLEN), .REGW(REGW)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en && !inv_res),
    .wr_idx_i  (dst_i),
    .wr_data_i (result_i),
    .snap_i    (entry),
    .restore_i (exit_now),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o)
  );

  assign rd_inv_o    = inv_vec[rd_idx_i];
  assign runahead_o  = ra;
  assign ckpt_o      = entry;
  assign restore_o   = exit_now;
  assign redirect_o  = exit_now;
  assign flush_o     = entry || exit_now;
  assign inv_o       = inv_res;
  assign mem_issue_o = issue;
endmodule

// File: rtl/ra_ctrl_chk.sv
`timescale 1ns/1ps
module ra_ctrl_chk #(
  parameter int NREG = 16,
  parameter int PCW  = 32,
  parameter int REGW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ins_valid_i,
  input logic [1:0]      ins_kind_i,
  input logic [REGW-1:0] src_a_i,
  input logic            line_busy_i,
  input logic [NREG-1:0] inv_vec,
  input logic            runahead_o,
  input logic            ckpt_o,
  input logic            restore_o,
  input logic [PCW-1:0]  redirect_pc_o,
  input logic            inv_o,
  input logic            mem_issue_o,
  input logic            dc_write_o,
  input logic            stall_o
);
  p_ckpt_normal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_o |-> !runahead_o);
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_o |=> runahead_o);
  p_no_cache_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    runahead_o |-> !dc_write_o);
  p_inv_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (runahead_o && ins_valid_i && (ins_kind_i == 2'd1 || ins_kind_i == 2'd2)
     && inv_vec[src_a_i]) |-> !mem_issue_o);
  p_busy_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (runahead_o && line_busy_i) |-> !mem_issue_o);
  p_stall_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (runahead_o && ins_kind_i == 2'd3));
  p_exit_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |=> !runahead_o);
  p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (runahead_o && $past(runahead_o)) |-> $stable(redirect_pc_o));
  p_squash_r11: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> (!mem_issue_o && !stall_o && !inv_o));
  p_inv_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |=> (inv_vec == '0));
  p_normal_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !runahead_o |-> (inv_vec == '0));
endmodule

bind runahead_ctrl ra_ctrl_chk #(.NREG(NREG), .PCW(PCW), .REGW(REGW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ins_valid_i   (ins_valid_i),
  .ins_kind_i    (ins_kind_i),
  .src_a_i       (src_a_i),
  .line_busy_i   (line_busy_i),
  .inv_vec       (inv_vec),
  .runahead_o    (runahead_o),
  .ckpt_o        (ckpt_o),
  .restore_o     (restore_o),
  .redirect_pc_o (redirect_pc_o),
  .inv_o         (inv_o),
  .mem_issue_o   (mem_issue_o),
  .dc_write_o    (dc_write_o),
  .stall_o       (stall_o)
);

// File: tb/sim_runahead_ctrl.sv
`timescale 1ns/1ps
module sim_runahead_ctrl;
  localparam int NREG = 16, XLEN = 32, PCW = 32, MAXO = 8, REGW = 4;
  localparam logic [1:0] ALU = 2'd0, LD = 2'd1, ST = 2'd2, BR = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exit_all, v, sb_used, dw, hit, busy, refill;
  logic [1:0] kind;
  logic [PCW-1:0] pc;
  logic [REGW-1:0] sa, sb, dst, rd_idx;
  logic [XLEN-1:0] data;
  logic [XLEN-1:0] rd_data;
  logic [PCW-1:0] rpc;
  logic rd_inv, ra_o, ckpt, rest, flush, redir, inv_o, issue, dcw, stall;

  always #4 clk = ~clk;

  runahead_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .exit_all_i(exit_all), .ins_valid_i(v),
    .ins_kind_i(kind), .ins_pc_i(pc), .src_a_i(sa), .src_b_i(sb),
    .src_b_used_i(sb_used), .dst_i(dst), .dst_wr_i(dw), .result_i(data),
    .dc_hit_i(hit), .line_busy_i(busy), .refill_done_i(refill),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_inv_o(rd_inv),
    .runahead_o(ra_o), .ckpt_o(ckpt), .restore_o(rest), .flush_o(flush),
    .redirect_o(redir), .redirect_pc_o(rpc), .inv_o(inv_o),
    .mem_issue_o(issue), .dc_write_o(dcw), .stall_o(stall)
  );

  int n_cmp = 0, n_bad = 0;
  logic [XLEN-1:0] m_arf [NREG];
  logic [XLEN-1:0] m_snap [NREG];
  logic [NREG-1:0] m_inv;
  logic m_ra, m_back, sweep_due;
  int m_out, m_ahead;
  logic [PCW-1:0] m_spc;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  // One cycle: inputs already driven after a negedge; check, clock, update model.
  task automatic step();
    logic m_exit, act, ainv, sinv, e_entry, e_inv, e_issue, e_dcw, e_stall;
    string itag;
    if (sweep_due) begin
      for (int r = 0; r < NREG; r++) begin
        rd_idx = REGW'(r);
        #0.1;
        chk("R10", rd_data, m_snap[r]);
        chk("R10", rd_inv, 1'b0);
      end
      sweep_due = 1'b0;
    end
    rd_idx = REGW'($urandom % NREG);
    #0.5;
    m_exit  = m_ra && m_back && (!exit_all || m_out == 0);
    act     = v && !m_exit;
    ainv    = m_inv[sa];
    sinv    = ainv || (sb_used && m_inv[sb]);
    e_entry = act && !m_ra && kind == LD && !hit;
    e_inv   = act && ((kind == ALU && sinv) || (kind == LD && (ainv || !hit)));
    e_issue = e_entry || (m_ra && act && (kind == LD || kind == ST) && !ainv
                          && !hit && !busy && m_out != MAXO);
    e_dcw   = act && !m_ra && kind == ST;
    e_stall = m_ra && act && kind == BR && sinv;
    itag = (m_exit && v) ? "R11" : (m_ra && ainv) ? "R4" : "R5";
    if (e_entry) itag = "R2";
    chk("R2 runahead", ra_o, m_ra);
    chk("R2 ckpt", ckpt, e_entry);
    chk("R2 flush", flush, e_entry || m_exit);
    chk((m_exit && v) ? "R11" : "R3", inv_o, e_inv);
    chk(itag, issue, e_issue);
    chk("R7", dcw, e_dcw);
    chk((m_exit && v) ? "R11" : "R6", stall, e_stall);
    chk(exit_all ? "R9" : "R8", rest, m_exit);
    chk("R8 redirect", redir, m_exit);
    if (m_exit || m_ra) chk("R8 pc", rpc, m_spc);
    chk("R3 rd", rd_data, m_arf[rd_idx]);
    chk("R3 inv", rd_inv, m_inv[rd_idx]);
    @(posedge clk);
    if (m_exit) begin
      for (int r = 0; r < NREG; r++) m_arf[r] = m_snap[r];
      m_inv = '0; m_ra = 1'b0; m_back = 1'b0; sweep_due = 1'b1;
    end else begin
      if (e_entry) begin
        for (int r = 0; r < NREG; r++) m_snap[r] = m_arf[r];
        m_ra = 1'b1; m_back = 1'b0; m_spc = pc; m_ahead = m_out - int'(refill);
      end else if (m_ra && refill && !m_back) begin
        if (m_ahead == 0) m_back = 1'b1; else m_ahead--;
      end
      if (act && dw && (kind == ALU || kind == LD)) begin
        if (e_inv) m_inv[dst] = 1'b1;
        else begin m_arf[dst] = data; m_inv[dst] = 1'b0; end
      end
    end
    m_out = m_out + int'(e_issue) - int'(refill);
    @(negedge clk);
  endtask

  task automatic ins(input logic [1:0] k, input int a, input int b, input logic ub,
                     input int d, input logic w, input logic h, input logic bz,
                     input logic rf, input logic [XLEN-1:0] dat);
    v = 1'b1; kind = k; sa = REGW'(a); sb = REGW'(b); sb_used = ub;
    dst = REGW'(d); dw = w; hit = h; busy = bz; refill = rf; data = dat;
    pc = $urandom;
    step();
  endtask

  task automatic idle(input logic rf);
    v = 1'b0; refill = rf; hit = 1'b1; busy = 1'b0; dw = 1'b0;
    step();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    exit_all = 1'b0; v = 1'b0; kind = ALU; pc = '0; sa = '0; sb = '0;
    sb_used = 1'b0; dst = '0; dw = 1'b0; data = '0; hit = 1'b1; busy = 1'b0;
    refill = 1'b0; rd_idx = '0; sweep_due = 1'b0;
    for (int r = 0; r < NREG; r++) begin m_arf[r] = '0; m_snap[r] = '0; end
    m_inv = '0; m_ra = 1'b0; m_back = 1'b0; m_out = 0; m_ahead = 0; m_spc = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int r = 0; r < NREG; r++) begin
      rd_idx = REGW'(r); #0.1;
      chk("R1 reg", rd_data, '0);
      chk("R1 inv", rd_inv, 1'b0);
    end
    chk("R1 mode", ra_o, 1'b0);
    chk("R1 strobes", {ckpt, rest, flush, stall, issue}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed, exit on offending return (R8)
    for (int r = 0; r < NREG; r++) ins(ALU, 0, 0, 0, r, 1, 1, 0, 0, 32'h100 + r);
    ins(LD, 1, 0, 0, 5, 1, 0, 0, 0, 32'hdead);        // R2 entry
    chk("R2 dst inv", m_inv[5], 1'b1);
    ins(ALU, 5, 2, 1, 6, 1, 1, 0, 0, 32'h66);         // R3 invalid propagation
    ins(BR, 6, 0, 0, 0, 0, 1, 0, 0, 0);               // R6 stall
    ins(LD, 6, 0, 0, 7, 1, 0, 0, 0, 0);               // R4 invalid address
    ins(LD, 2, 0, 0, 8, 1, 0, 1, 0, 0);               // R5 busy line
    ins(LD, 3, 0, 0, 9, 1, 0, 0, 0, 0);               // R5 prefetch
    ins(ST, 3, 4, 1, 0, 0, 1, 0, 0, 0);               // R7 no write
    ins(ALU, 2, 3, 1, 5, 1, 1, 0, 0, 32'hbeef);       // R3 clear inv
    idle(1'b1);                                       // offending refill
    ins(LD, 2, 0, 0, 10, 1, 0, 0, 0, 0);              // R11 exit-cycle squash
    idle(1'b0);                                       // R10 sweep
    // Directed, wait for all requests (R9); one prefetch still outstanding
    exit_all = 1'b1;
    ins(ALU, 0, 0, 0, 3, 1, 1, 0, 0, 32'h3333);
    ins(LD, 4, 0, 0, 11, 1, 0, 0, 0, 0);              // entry, one request ahead
    ins(ST, 2, 0, 0, 0, 0, 0, 0, 0, 0);               // prefetch
    idle(1'b1);
    idle(1'b1);                                       // offending returns
    idle(1'b0);                                       // R9: still outstanding
    idle(1'b1);
    idle(1'b0);                                       // exit cycle
    idle(1'b0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] k;
      if (i % 500 == 0) exit_all = $urandom % 2;
      k = 2'($urandom);
      ins(k, $urandom % NREG, $urandom % NREG, 1'($urandom), $urandom % NREG,
          ($urandom % 4) != 0, ($urandom % 5) < 3, ($urandom % 4) == 0,
          (m_out > 0) && (($urandom % 4) == 0), $urandom);
      if ($urandom % 8 == 0) idle((m_out > 0) && (($urandom % 2) == 0));
    end
    summary();
    $finish;
  end
endmodule